// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block controls 64 general-purpose I/O lines arranged as eight groups of eight. Line n sits in group n/8 at bit n mod 8. Direction is programmed through a byte-wide configuration port, indexed by an 8-bit register index. That port holds three things: a per-group output-enable register, a per-group simple-I/O-enable switch, and a 16-bit base address for the data window. The switch exists only for the lower groups.

Pin values are written and read through a small byte window in I/O space. The window starts at the programmed base and holds one data register per group. Software changes a single line by reading its group, modifying the bit and writing the byte back. A read reports the driven value for lines that drive and the pad level for all other lines, so the write-back leaves the other outputs as they were.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Line n is controlled by bit n mod 8 of the registers of group n/8, and maps to pin_in[n], pin_out[n] and pin_oe[n].
- R2: An I/O write to address base + g, for g from 0 to 7, loads the output values of group g. Writes to addresses below base or at base + 8 and above change no output value.
- R3: The cycle after an I/O read, io_rdata holds the group's readback: pin_out for lines whose pin_oe is 1 and pin_in for the other lines. A read outside the window returns 0x00.
- R4: Configuration index 0xC8 + g holds the output-enable byte of group g. pin_oe[n] is never 1 while the output-enable bit of line n is 0.
- R5: Configuration index 0xC0 + g, for g from 0 to 4, holds the simple-I/O switch byte of group g. A line in those groups drives (pin_oe = 1) only when both its switch bit and its output-enable bit are 1.
- R6: Indexes 0xC5 to 0xC7 read 0xFF and ignore writes. Lines of groups 5 to 7 drive whenever their output-enable bit is 1.
- R7: The window base is the 16-bit value at configuration indexes 0x62 (high byte) and 0x63 (low byte). Both bytes can be read back.
- R8: While the base is 0x0000, I/O writes change no output value and I/O reads return 0x00.
- R9: After reset, all output enables, switch bytes, output values and the base are 0, so pin_oe and pin_out are all 0.
- R10: The cycle after a configuration read, cfg_rdata holds the addressed register. An index that names no register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, valid the cycle after cfg_rd |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid the cycle after io_rd |
| pin_in | input | 64 | Pad input levels |
| pin_out | output | 64 | Output values |
| pin_oe | output | 64 | Output enables to the pads |

## Verification
Four things are watched on every cycle: no line drives without its output-enable bit, the outputs and enables are idle right after reset, the upper switch indexes read as all ones, and out-of-window reads return zero. The same watch confirms that nothing in the data registers moves while the base is zero. The bench scenarios are needed for the rest. They show the base split between its high and low index, the window edges at base - 1 and base + 8, and the mixed readback of driven and undriven lines in one group. They also show that an output-enable byte has no effect on a lower group until its switch is set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int GRP_W    = 8;
    localparam int NUM_GRP  = 8;
    localparam int SIO_GRP  = 5;
    localparam int ADDR_W   = 16;
    localparam int IDX_W    = 8;

    localparam logic [IDX_W-1:0] IDX_SIO     = 8'hC0;
    localparam logic [IDX_W-1:0] IDX_OE      = 8'hC8;
    localparam logic [IDX_W-1:0] IDX_BASE_HI = 8'h62;
    localparam logic [IDX_W-1:0] IDX_BASE_LO = 8'h63;

    typedef logic [GRP_W-1:0] grp_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [IDX_W-1:0] idx;
        grp_t             wdata;
    } cfg_req_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        grp_t              wdata;
    } io_req_t;

    function automatic logic idx_is(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] bank, int g);
        return idx == IDX_W'(int'(bank) + g);
    endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NGRP = NUM_GRP,
    parameter int NSIO = SIO_GRP,
    localparam int LINES = NGRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_req_t          req,
    output grp_t              rdata,
    output logic [LINES-1:0]  oe_flat,
    output logic [LINES-1:0]  sio_flat,
    output logic [ADDR_W-1:0] base
);
    grp_t base_hi, base_lo;
    grp_t rd_val;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        grp_t oe_r;
        always_ff @(posedge clk) begin
            if (rst)
                oe_r <= '0;
            else if (req.wr && idx_is(req.idx, IDX_OE, g))
                oe_r <= req.wdata;
        end
        assign oe_flat[g*GRP_W +: GRP_W] = oe_r;

        if (g < NSIO) begin : g_switch
            grp_t sio_r;
            always_ff @(posedge clk) begin
                if (rst)
                    sio_r <= '0;
                else if (req.wr && idx_is(req.idx, IDX_SIO, g))
                    sio_r <= req.wdata;
            end
            assign sio_flat[g*GRP_W +: GRP_W] = sio_r;
        end else begin : g_fixed
            assign sio_flat[g*GRP_W +: GRP_W] = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            base_lo <= '0;
        end else if (req.wr) begin
            if (req.idx == IDX_BASE_HI) base_hi <= req.wdata;
            if (req.idx == IDX_BASE_LO) base_lo <= req.wdata;
        end
    end
    assign base = {base_hi, base_lo};

    always_comb begin
        rd_val = '0;
        if (req.idx == IDX_BASE_HI) rd_val = base_hi;
        if (req.idx == IDX_BASE_LO) rd_val = base_lo;
        for (int g = 0; g < NGRP; g++) begin
            if (idx_is(req.idx, IDX_OE, g))  rd_val = oe_flat[g*GRP_W +: GRP_W];
            if (idx_is(req.idx, IDX_SIO, g)) rd_val = sio_flat[g*GRP_W +: GRP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.rd)
            rdata <= rd_val;
    end

    // R6: switch indexes above the implemented groups read as all ones
    p_fixed_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.idx >= IDX_W'(int'(IDX_SIO) + NSIO) && req.idx < IDX_W'(int'(IDX_SIO) + NGRP))
        |=> (rdata == 8'hFF));
endmodule

// File: rtl/gpio_data_window.sv
module gpio_data_window
    import gpio_bank_pkg::*;
#(
    parameter int NGRP = NUM_GRP,
    localparam int LINES = NGRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  io_req_t           req,
    input  logic [ADDR_W-1:0] base,
    input  logic [LINES-1:0]  pin_in,
    input  logic [LINES-1:0]  drive,
    output grp_t              rdata,
    output logic [LINES-1:0]  dout
);
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [LINES-1:0]  readback;
    grp_t              rd_val;

    assign off      = req.addr - base;
    assign hit      = (base != '0) && (req.addr >= base) && (off < ADDR_W'(NGRP));
    assign readback = (drive & dout) | (~drive & pin_in);

    for (genvar g = 0; g < NGRP; g++) begin : g_data
        grp_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (req.wr && hit && off == ADDR_W'(g))
                q <= req.wdata;
        end
        assign dout[g*GRP_W +: GRP_W] = q;
    end

    always_comb begin
        rd_val = '0;
        for (int g = 0; g < NGRP; g++)
            if (off == ADDR_W'(g)) rd_val = readback[g*GRP_W +: GRP_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.rd)
            rdata <= hit ? rd_val : '0;
    end

    // R8: a zero base freezes the output values
    p_zero_base_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (base == '0) |=> $stable(dout));

    // R3: reads that miss the window return zero
    p_miss_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !hit) |=> (rdata == '0));
endmodule

// File: rtl/gpio_pad_gate.sv
module gpio_pad_gate
    import gpio_bank_pkg::*;
#(
    parameter int NGRP = NUM_GRP,
    localparam int LINES = NGRP * GRP_W
) (
    input  logic [LINES-1:0] oe_flat,
    input  logic [LINES-1:0] sio_flat,
    output logic [LINES-1:0] drive
);
    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        assign drive[g*GRP_W +: GRP_W] = oe_flat[g*GRP_W +: GRP_W] & sio_flat[g*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NGRP = NUM_GRP,
    parameter int NSIO = SIO_GRP,
    localparam int LINES = NGRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [GRP_W-1:0]  cfg_wdata,
    output logic [GRP_W-1:0]  cfg_rdata,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [GRP_W-1:0]  io_wdata,
    output logic [GRP_W-1:0]  io_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe
);
    cfg_req_t          creq;
    io_req_t           ireq;
    logic [LINES-1:0]  oe_flat, sio_flat;
    logic [ADDR_W-1:0] base;

    assign creq = '{wr: cfg_wr, rd: cfg_rd, idx: cfg_idx, wdata: cfg_wdata};
    assign ireq = '{wr: io_wr, rd: io_rd, addr: io_addr, wdata: io_wdata};

    gpio_cfg_regs #(.NGRP(NGRP), .NSIO(NSIO)) u_cfg (
        .clk(clk), .rst(rst), .req(creq), .rdata(cfg_rdata),
        .oe_flat(oe_flat), .sio_flat(sio_flat), .base(base)
    );

    gpio_pad_gate #(.NGRP(NGRP)) u_gate (
        .oe_flat(oe_flat), .sio_flat(sio_flat), .drive(pin_oe)
    );

    gpio_data_window #(.NGRP(NGRP)) u_win (
        .clk(clk), .rst(rst), .req(ireq), .base(base), .pin_in(pin_in),
        .drive(pin_oe), .rdata(io_rdata), .dout(pin_out)
    );

    // R4: no line drives without its output-enable bit
    p_drive_needs_oe_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~oe_flat) == '0);

    // R9: outputs idle right after reset
    p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h0A40;

    logic        clk = 0, rst = 1;
    logic        cfg_wr = 0, cfg_rd = 0, io_wr = 0, io_rd = 0;
    logic [7:0]  cfg_idx = 0, cfg_wdata = 0, io_wdata = 0;
    logic [15:0] io_addr = 0;
    logic [7:0]  cfg_rdata, io_rdata;
    logic [63:0] pin_in = 64'hC3A5_0F96_5A3C_E718;
    logic [63:0] pin_out, pin_oe;
    logic [63:0] exp_out = 0, exp_oe = 0;
    int total = 0, bad = 0;
    logic [7:0] rv;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] idx, logic [7:0] d);
        @(negedge clk); cfg_wr = 1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic cfg_read(logic [7:0] idx, output logic [7:0] d);
        @(negedge clk); cfg_rd = 1; cfg_idx = idx;
        @(negedge clk); cfg_rd = 0; d = cfg_rdata;
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 0;
    endtask

    task automatic io_read(logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_rd = 1; io_addr = a;
        @(negedge clk); io_rd = 0; d = io_rdata;
    endtask

    task automatic t_reset();
        chk("R9 pin_oe after reset", pin_oe, 0);
        chk("R9 pin_out after reset", pin_out, 0);
        cfg_read(8'hC8, rv); chk("R9 oe byte after reset", rv, 0);
        cfg_read(8'hC2, rv); chk("R9 switch byte after reset", rv, 0);
        cfg_read(8'h62, rv); chk("R9 base after reset", rv, 0);
    endtask

    task automatic t_zero_base();
        io_write(16'h0000, 8'hAA);
        io_write(16'h0003, 8'h55);
        chk("R8 write ignored at zero base", pin_out, 0);
        io_read(16'h0000, rv); chk("R8 read zero at zero base", rv, 0);
    endtask

    task automatic t_base();
        cfg_write(8'h62, BASE[15:8]);
        cfg_write(8'h63, BASE[7:0]);
        cfg_read(8'h62, rv); chk("R7 base high byte", rv, BASE[15:8]);
        cfg_read(8'h63, rv); chk("R7 base low byte", rv, BASE[7:0]);
        cfg_read(8'h10, rv); chk("R10 unknown index reads zero", rv, 0);
    endtask

    task automatic t_data();
        for (int g = 0; g < 8; g++) begin
            io_write(BASE + 16'(g), 8'(8'h13 * (g + 1)));
            exp_out[g*8 +: 8] = 8'(8'h13 * (g + 1));
        end
        chk("R2 all groups written", pin_out, exp_out);
        io_write(BASE + 16'd8, 8'hFF);
        io_write(BASE - 16'd1, 8'hFF);
        chk("R2 window edges ignored", pin_out, exp_out);
        io_write(BASE + 16'd1, exp_out[15:8] ^ 8'h20);
        exp_out[13] = ~exp_out[13];
        chk("R1 line 13 is group 1 bit 5", pin_out, exp_out);
    endtask

    task automatic t_direction();
        cfg_write(8'hCE, 8'hF0); exp_oe[55:48] = 8'hF0;
        chk("R6 group 6 drives by oe alone", pin_oe, exp_oe);
        cfg_write(8'hC9, 8'hFF);
        chk("R5 group 1 blocked without switch", pin_oe, exp_oe);
        cfg_write(8'hC1, 8'h0F); exp_oe[15:8] = 8'h0F;
        chk("R5 group 1 with switch", pin_oe, exp_oe);
        cfg_read(8'hC1, rv); chk("R10 switch readback", rv, 8'h0F);
        cfg_read(8'hC9, rv); chk("R4 oe readback", rv, 8'hFF);
        cfg_write(8'hC9, 8'h03); exp_oe[15:8] = 8'h03;
        chk("R4 oe bits gate line", pin_oe, exp_oe);
    endtask

    task automatic t_fixed_switch();
        cfg_write(8'hC6, 8'h00);
        cfg_read(8'hC6, rv); chk("R6 upper switch reads FF", rv, 8'hFF);
        chk("R6 upper switch write ignored", pin_oe, exp_oe);
    endtask

    task automatic t_readback();
        io_read(BASE + 16'd6, rv);
        chk("R3 mixed readback group 6", rv, (exp_out[55:48] & 8'hF0) | (pin_in[55:48] & 8'h0F));
        io_read(BASE + 16'd0, rv);
        chk("R3 input readback group 0", rv, pin_in[7:0]);
        pin_in = ~pin_in;
        io_read(BASE + 16'd1, rv);
        chk("R3 readback after pad change", rv, (exp_out[15:8] & 8'h03) | (pin_in[15:8] & 8'hFC));
        io_read(BASE + 16'd8, rv);
        chk("R3 miss reads zero", rv, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_zero_base();
        t_base();
        t_data();
        t_direction();
        t_fixed_switch();
        t_readback();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule